// File: doc/BRIEF.md
# Multi-Rate Quasi-Cyclic LDPC Systematic Encoder

This block turns a serial stream of information bits into systematic quasi-cyclic LDPC codewords at one of three code rates (2/5, 3/5, 4/5). A rate code on `mode_i` is captured with the first bit of each block. The block then takes `k·B` information bits, where `k` is 2, 3 or 4 information circulants of size `B`. Every codeword is `5·B` bits long: the `k·B` information bits followed by `(5−k)·B` parity bits.

Parity comes from up to three multiply-accumulate lanes, one for each parity circulant. Each lane has its own small generator store, which holds the first rows of its circulants for every rate that uses that lane. On the first bit of each information circulant, a lane loads that circulant's first row into a rotating register. Each accepted bit is ANDed with the register and XORed into the lane's parity register. The register then rotates one place.

Finished codewords go to one of two output banks. Readout of one bank runs one bit per cycle under `out_ready_i`, while the next block fills the other bank. Input is held off only when both banks hold unread codewords.

Top module: `qc_ldpc_enc`

## Requirements
- R1: After reset `ready_o` is 1 and `out_valid_o` is 0.
- R2: Mode code 2'b00 selects k=2 (3 parity circulants), 2'b01 selects k=3 (2 parity), and 2'b10 selects k=4 (1 parity). Code 2'b11 behaves as 2'b10 and is reported as 2'b10 on `out_mode_o`.
- R3: Let u[n] be the n-th information bit of the block. Let g(m,i,j)[t]=1 exactly when (t·(2i+3)+5j+7m+1) mod 4 = 0. Parity circulant j bit t is then the XOR over i<k and s<B of u[i·B+s] & g(m,i,j)[(t−s) mod B].
- R4: `out_valid_o` is 0 after k·B−1 bits of a block have been accepted, and it is 1 in the cycle right after the k·B-th bit is accepted.
- R5: A codeword is read out as 5·B bits. Bit r is u[r] for r<k·B, and bit k·B+j·B+t is parity circulant j bit t. `out_last_o` is 1 only on bit 5·B−1, and `out_mode_o` gives the block's rate code.
- R6: The rate is taken from `mode_i` only on a bit accepted with `sob_i`=1. Changes on `mode_i` during a block have no effect on that codeword.
- R7: A bit accepted with `sob_i`=1 always starts a new block and clears the parity registers, even if a block is in progress. The partial block produces no codeword.
- R8: A bit accepted with `sob_i`=0 while no block is in progress is discarded and produces no output.
- R9: Up to two finished codewords are held. `ready_o` is 0 exactly while both banks are unread. A new block can be accepted while an older codeword is being read out.
- R10: A bit is consumed when `out_valid_o` and `out_ready_i` are both 1. While `out_ready_i` is 0, `out_data_o`, `out_last_o` and `out_mode_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Rate code, captured with the first bit of a block |
| sob_i | input | 1 | Marks the first information bit of a block |
| valid_i | input | 1 | Information bit present |
| data_i | input | 1 | Information bit |
| ready_o | output | 1 | Encoder can take a bit |
| out_ready_i | input | 1 | Consumer takes the current codeword bit |
| out_valid_o | output | 1 | Codeword bit present |
| out_data_o | output | 1 | Codeword bit |
| out_last_o | output | 1 | Final bit of the codeword |
| out_mode_o | output | 2 | Rate code of the codeword being read |

## Verification
A lane whose rotating register misses a load or rotates the wrong way corrupts only its own parity circulant. That error first shows at readout bit k·B+j·B, one block after the fault. Single-bit information patterns isolate each generator row.

A stray count in the bit or circulant counters shifts the cycle in which `out_valid_o` rises, and this is visible at once. A rate latched at the wrong time changes both `out_mode_o` and the split between information and parity. Bank bookkeeping errors appear as a lost, repeated or misordered codeword when two blocks are queued.

// File: rtl/qc_enc_pkg.sv
package qc_enc_pkg;
  localparam int unsigned NCOL = 5;
  localparam int unsigned KMIN = 2;
  localparam int unsigned KMAX = 4;
  localparam int unsigned NPAR = NCOL - KMIN;

  // fold the spare code onto the highest rate
  function automatic logic [1:0] norm_mode(input logic [1:0] m);
    return (m == 2'b11) ? 2'b10 : m;
  endfunction

  function automatic logic [2:0] info_circ(input logic [1:0] m);
    case (m)
      2'b00:   return 3'd2;
      2'b01:   return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  // synthetic generator first-row pattern
  function automatic logic gen_bit(input int m, input int i, input int j, input int t);
    return ((t * (2 * i + 3) + 5 * j + 7 * m + 1) % 4) == 0;
  endfunction
endpackage

// File: rtl/qc_gen_rom.sv
module qc_gen_rom
  import qc_enc_pkg::*;
#(
  parameter int unsigned B    = 8,
  parameter int unsigned UNIT = 0,
  parameter int unsigned CW   = 2
) (
  input  logic [1:0]    mode_i,
  input  logic [CW-1:0] circ_i,
  output logic [B-1:0]  row_o
);
  logic active;
  assign active = UNIT < (NCOL - int'(info_circ(mode_i)));

  always_comb begin
    for (int t = 0; t < int'(B); t++)
      row_o[t] = active & gen_bit(int'(mode_i), int'(circ_i), int'(UNIT), t);
  end
endmodule

// File: rtl/qc_mac_unit.sv
module qc_mac_unit #(
  parameter int unsigned B = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [B-1:0] row_i,
  input  logic         bit_i,
  output logic [B-1:0] acc_nxt_o
);
  logic [B-1:0] sr_q, acc_q, eff_row, prod;

  assign eff_row   = load_i ? row_i : sr_q;
  assign prod      = bit_i ? eff_row : '0;
  assign acc_nxt_o = (clr_i ? '0 : acc_q) ^ prod;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      acc_q <= '0;
    end else if (en_i) begin
      sr_q  <= {eff_row[B-2:0], eff_row[B-1]};
      acc_q <= acc_nxt_o;
    end
  end
endmodule

// File: rtl/qc_pingpong_buf.sv
module qc_pingpong_buf #(
  parameter int unsigned N = 40
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [$clog2(N)-1:0] wr_idx_i,
  input  logic                 wr_bit_i,
  input  logic                 commit_i,
  input  logic [1:0]           commit_mode_i,
  input  logic [N-1:0]         par_vec_i,
  input  logic [N-1:0]         par_mask_i,
  output logic                 wr_free_o,
  input  logic                 rd_ready_i,
  output logic                 rd_valid_o,
  output logic                 rd_bit_o,
  output logic                 rd_last_o,
  output logic [1:0]           rd_mode_o
);
  localparam int unsigned IW = $clog2(N);

  logic [N-1:0]  bank_q   [2];
  logic [N-1:0]  bank_nxt [2];
  logic [1:0]    bmode_q  [2];
  logic [1:0]    full_q;
  logic          wr_sel_q, rd_sel_q;
  logic [IW-1:0] rd_ptr_q;
  logic          rd_fire, rd_done;

  assign wr_free_o  = !full_q[wr_sel_q];
  assign rd_valid_o = full_q[rd_sel_q];
  assign rd_bit_o   = bank_q[rd_sel_q][rd_ptr_q];
  assign rd_last_o  = rd_valid_o && (rd_ptr_q == IW'(N - 1));
  assign rd_mode_o  = bmode_q[rd_sel_q];
  assign rd_fire    = rd_valid_o && rd_ready_i;
  assign rd_done    = rd_fire && (rd_ptr_q == IW'(N - 1));

  for (genvar g = 0; g < 2; g++) begin : g_bank
    always_comb begin
      bank_nxt[g] = bank_q[g];
      bank_nxt[g][wr_idx_i] = wr_bit_i;
      if (commit_i) bank_nxt[g] = (bank_nxt[g] & ~par_mask_i) | (par_vec_i & par_mask_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bank_q[g]  <= '0;
        bmode_q[g] <= '0;
        full_q[g]  <= 1'b0;
      end else begin
        if (wr_en_i && wr_sel_q == 1'(g)) bank_q[g] <= bank_nxt[g];
        if (commit_i && wr_sel_q == 1'(g)) begin
          full_q[g]  <= 1'b1;
          bmode_q[g] <= commit_mode_i;
        end else if (rd_done && rd_sel_q == 1'(g)) begin
          full_q[g] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_sel_q <= 1'b0;
      rd_sel_q <= 1'b0;
      rd_ptr_q <= '0;
    end else begin
      if (commit_i) wr_sel_q <= !wr_sel_q;
      if (rd_done) begin
        rd_ptr_q <= '0;
        rd_sel_q <= !rd_sel_q;
      end else if (rd_fire) begin
        rd_ptr_q <= rd_ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/qc_ldpc_enc.sv
module qc_ldpc_enc
  import qc_enc_pkg::*;
#(
  parameter int unsigned B = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       sob_i,
  input  logic       valid_i,
  input  logic       data_i,
  output logic       ready_o,
  input  logic       out_ready_i,
  output logic       out_valid_o,
  output logic       out_data_o,
  output logic       out_last_o,
  output logic [1:0] out_mode_o
);
  localparam int unsigned N  = NCOL * B;
  localparam int unsigned BW = $clog2(B);
  localparam int unsigned CW = $clog2(KMAX);
  localparam int unsigned IW = $clog2(N);

  logic          in_blk_q;
  logic [1:0]    mode_q, cur_mode;
  logic [CW-1:0] circ_q, cur_circ;
  logic [BW-1:0] bit_q, cur_bit;
  logic [2:0]    k_cur;
  logic          wr_free, accept, start, take, last_bit, circ_end;
  logic [IW-1:0] wr_idx;
  logic [N-1:0]  par_vec, par_mask;
  logic [B-1:0]  rom_row [NPAR];
  logic [B-1:0]  acc_nxt [NPAR];

  assign ready_o  = wr_free;
  assign accept   = valid_i && wr_free;
  assign start    = accept && sob_i;
  assign take     = accept && (sob_i || in_blk_q);
  assign cur_mode = start ? norm_mode(mode_i) : mode_q;
  assign cur_circ = start ? '0 : circ_q;
  assign cur_bit  = start ? '0 : bit_q;
  assign k_cur    = info_circ(cur_mode);
  assign circ_end = cur_bit == BW'(B - 1);
  assign last_bit = take && circ_end && (cur_circ == CW'(k_cur - 3'd1));
  assign wr_idx   = IW'(int'(cur_circ) * int'(B) + int'(cur_bit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_blk_q <= 1'b0;
      mode_q   <= '0;
      circ_q   <= '0;
      bit_q    <= '0;
    end else if (take) begin
      mode_q <= cur_mode;
      if (last_bit) begin
        in_blk_q <= 1'b0;
        circ_q   <= '0;
        bit_q    <= '0;
      end else begin
        in_blk_q <= 1'b1;
        bit_q    <= circ_end ? '0 : cur_bit + 1'b1;
        circ_q   <= circ_end ? cur_circ + 1'b1 : cur_circ;
      end
    end
  end

  for (genvar j = 0; j < int'(NPAR); j++) begin : g_lane
    qc_gen_rom #(.B(B), .UNIT(j), .CW(CW)) u_rom (
      .mode_i (cur_mode),
      .circ_i (cur_circ),
      .row_o  (rom_row[j])
    );
    qc_mac_unit #(.B(B)) u_mac (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (take),
      .clr_i     (start),
      .load_i    (cur_bit == '0),
      .row_i     (rom_row[j]),
      .bit_i     (data_i),
      .acc_nxt_o (acc_nxt[j])
    );
  end

  // place each lane's parity after the information part
  always_comb begin
    par_vec  = '0;
    par_mask = '0;
    for (int j = 0; j < int'(NPAR); j++) begin
      if (j < int'(NCOL) - int'(k_cur)) begin
        for (int t = 0; t < int'(B); t++) begin
          par_vec[(int'(k_cur) + j) * int'(B) + t]  = acc_nxt[j][t];
          par_mask[(int'(k_cur) + j) * int'(B) + t] = 1'b1;
        end
      end
    end
  end

  qc_pingpong_buf #(.N(N)) u_buf (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (take),
    .wr_idx_i      (wr_idx),
    .wr_bit_i      (data_i),
    .commit_i      (last_bit),
    .commit_mode_i (cur_mode),
    .par_vec_i     (par_vec),
    .par_mask_i    (par_mask),
    .wr_free_o     (wr_free),
    .rd_ready_i    (out_ready_i),
    .rd_valid_o    (out_valid_o),
    .rd_bit_o      (out_data_o),
    .rd_last_o     (out_last_o),
    .rd_mode_o     (out_mode_o)
  );
endmodule

// File: rtl/qc_ldpc_enc_chk.sv
module qc_ldpc_enc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       sob_i,
  input logic       ready_o,
  input logic       out_ready_i,
  input logic       out_valid_o,
  input logic       out_data_o,
  input logic       out_last_o,
  input logic [1:0] out_mode_o,
  input logic       in_blk_q,
  input logic [1:0] mode_q
);
  a_r10_hold_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
                                    && $stable(out_last_o) && $stable(out_mode_o));

  a_r5_last_has_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);

  a_r9_stall_means_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> out_valid_o);

  a_r6_rate_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_blk_q && !(valid_i && ready_o && sob_i) |=> $stable(mode_q));

  a_r2_mode_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_mode_o != 2'b11);
endmodule

bind qc_ldpc_enc qc_ldpc_enc_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .sob_i       (sob_i),
  .ready_o     (ready_o),
  .out_ready_i (out_ready_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o),
  .out_mode_o  (out_mode_o),
  .in_blk_q    (in_blk_q),
  .mode_q      (mode_q)
);

// File: tb/sim_qc_ldpc_enc.sv
`timescale 1ns/1ps
module sim_qc_ldpc_enc;
  localparam int B = 8;
  localparam int N = 5 * B;
  localparam int NV = 6;
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 32'h0000_0001}, {2'd0, 32'h0000_a5c3}, {2'd1, 32'h0000_0000},
    {2'd1, 32'h00f0_3c81}, {2'd2, 32'h8000_0000}, {2'd3, 32'hdead_beef}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode_i = '0;
  logic sob_i = 0, valid_i = 0, data_i = 0, out_ready_i = 0;
  logic ready_o, out_valid_o, out_data_o, out_last_o;
  logic [1:0] out_mode_o;
  int total = 0, bad = 0, cyc = 0;
  bit mid_en = 0;
  logic [1:0] mid_mode = '0;

  always #2.5 clk = ~clk;

  qc_ldpc_enc #(.B(B)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_i), .sob_i(sob_i), .valid_i(valid_i),
    .data_i(data_i), .ready_o(ready_o), .out_ready_i(out_ready_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_last_o(out_last_o),
    .out_mode_o(out_mode_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int nmode(input logic [1:0] m);
    return (m == 2'b11) ? 2 : int'(m);
  endfunction

  function automatic int kof(input logic [1:0] m);
    return nmode(m) + 2;
  endfunction

  function automatic bit g(input int m, input int i, input int j, input int t);
    return ((t * (2 * i + 3) + 5 * j + 7 * m + 1) % 4) == 0;
  endfunction

  function automatic logic [N-1:0] exp_cw(input logic [1:0] md, input logic [31:0] info);
    logic [N-1:0] cw = '0;
    int m = nmode(md);
    int k = kof(md);
    for (int n = 0; n < k * B; n++) cw[n] = info[n];
    for (int j = 0; j < 5 - k; j++)
      for (int t = 0; t < B; t++) begin
        bit p = 0;
        for (int i = 0; i < k; i++)
          for (int s = 0; s < B; s++)
            p ^= info[i * B + s] & g(m, i, j, (t - s + B) % B);
        cw[(k + j) * B + t] = p;
      end
    return cw;
  endfunction

  task automatic send_range(input logic [1:0] m, input logic [31:0] info, input int lo, input int hi);
    for (int n = lo; n < hi; n++) begin
      @(negedge clk);
      valid_i = 1; data_i = info[n]; sob_i = (n == 0);
      mode_i = (mid_en && n >= B) ? mid_mode : m;
      while (!ready_o) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    valid_i = 0; sob_i = 0;
  endtask

  task automatic read_cw(output logic [N-1:0] cw, output logic [1:0] md, output int lerr);
    int idx = 0;
    lerr = 0; cw = '0; md = '0;
    while (idx < N) begin
      @(negedge clk);
      if (out_valid_o) begin
        cw[idx] = out_data_o;
        if (idx == 0) md = out_mode_o;
        if (out_last_o != (idx == N - 1)) lerr++;
        out_ready_i = 1;
        idx++;
      end else out_ready_i = 0;
    end
    @(posedge clk);
    #1 out_ready_i = 0;
  endtask

  task automatic check_cw(input string req, input logic [1:0] m, input logic [31:0] info);
    logic [N-1:0] cw;
    logic [1:0] md;
    int lerr;
    read_cw(cw, md, lerr);
    chk(cw == exp_cw(m, info), req, 64'(cw), 64'(exp_cw(m, info)));
    chk(md == 2'(nmode(m)), "R5 mode", 64'(md), 64'(nmode(m)));
    chk(lerr == 0, "R5 last", 64'(lerr), 64'd0);
  endtask

  initial begin
    logic d0, l0;
    #12 rst_n = 1;
    @(negedge clk);
    chk(ready_o == 1, "R1 ready", 64'(ready_o), 64'd1);
    chk(out_valid_o == 0, "R1 valid", 64'(out_valid_o), 64'd0);

    // R3 R2 R5: vector table
    for (int v = 0; v < NV; v++) begin
      send_range(VEC[v][33:32], VEC[v][31:0], 0, kof(VEC[v][33:32]) * B);
      check_cw("R3 codeword", VEC[v][33:32], VEC[v][31:0]);
    end

    // R4 latency
    send_range(2'd1, 32'h0013_57bd, 0, 3 * B - 1);
    chk(out_valid_o == 0, "R4 early", 64'(out_valid_o), 64'd0);
    send_range(2'd1, 32'h0013_57bd, 3 * B - 1, 3 * B);
    chk(out_valid_o == 1, "R4 on time", 64'(out_valid_o), 64'd1);
    check_cw("R4 codeword", 2'd1, 32'h0013_57bd);

    // R6 mid-block mode change ignored
    mid_en = 1; mid_mode = 2'd2;
    send_range(2'd0, 32'h0000_9e37, 0, 2 * B);
    mid_en = 0;
    check_cw("R6 codeword", 2'd0, 32'h0000_9e37);

    // R7 restart with a new start-of-block
    send_range(2'd2, 32'hffff_ffff, 0, 10);
    chk(out_valid_o == 0, "R7 partial", 64'(out_valid_o), 64'd0);
    send_range(2'd1, 32'h00c6_1a44, 0, 3 * B);
    check_cw("R7 codeword", 2'd1, 32'h00c6_1a44);
    @(negedge clk);
    chk(out_valid_o == 0, "R7 no extra", 64'(out_valid_o), 64'd0);

    // R8 stray bits outside a block
    for (int n = 0; n < 5; n++) begin
      @(negedge clk); valid_i = 1; data_i = 1; sob_i = 0; @(posedge clk);
    end
    @(negedge clk); valid_i = 0;
    repeat (3) @(negedge clk);
    chk(out_valid_o == 0, "R8 stray", 64'(out_valid_o), 64'd0);
    send_range(2'd0, 32'h0000_0180, 0, 2 * B);
    check_cw("R8 codeword", 2'd0, 32'h0000_0180);

    // R9 ping-pong and R10 hold
    send_range(2'd2, 32'h1234_5678, 0, 4 * B);
    chk(ready_o == 1, "R9 one bank", 64'(ready_o), 64'd1);
    send_range(2'd0, 32'h0000_f00d, 0, 2 * B);
    chk(ready_o == 0, "R9 both full", 64'(ready_o), 64'd0);
    d0 = out_data_o; l0 = out_last_o;
    repeat (4) @(negedge clk);
    chk(out_valid_o == 1 && out_data_o == d0 && out_last_o == l0, "R10 hold",
        64'({out_valid_o, out_data_o, out_last_o}), 64'({1'b1, d0, l0}));
    fork
      send_range(2'd1, 32'h00ab_cdef, 0, 3 * B);
      begin
        check_cw("R9 first", 2'd2, 32'h1234_5678);
        check_cw("R9 second", 2'd0, 32'h0000_f00d);
        check_cw("R9 third", 2'd1, 32'h00ab_cdef);
      end
    join
    @(negedge clk);
    chk(ready_o == 1 && out_valid_o == 0, "R9 drained",
        64'({ready_o, out_valid_o}), 64'({1'b1, 1'b0}));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule